// File: doc/BRIEF.md
# Zero-Overhead Hardware Loop Controller

This block gives a simple processor front end counted loops that cost no instructions and no cycles for loop control. The decoder presents a loop-setup instruction with its own address, an iteration count and a body length in instructions. The controller stores the body as the address range that starts just after the setup instruction. It then watches the fetch program counter. When the last body address is fetched and passes remain, it raises a redirect in that same cycle, so the next fetch is the first body instruction again. On the final pass it lets fetch fall through to the instruction after the body. No add instruction and no backward branch are needed.

The block handles one loop level. A setup that arrives while a loop runs is dropped and reported on an error flag. An abort input, driven on a pipeline flush, kills the running loop at once. A setup whose count or length is zero never starts a loop. It redirects fetch past the body instead. The fetch of the first body instruction must come at least one cycle after the setup cycle. Address arithmetic wraps modulo 2^PC_W.

Top module: `hwloop_ctrl`

## Requirements
- R1: After reset, loop_active is 0, loop_count is 0, redirect_valid is 0 and setup_err is 0.
- R2: An accepted setup with setup_count N >= 1 and setup_len L >= 1 (no abort, no loop active) makes loop_active 1 and loop_count N in the next cycle. The body runs from setup_pc+1 to setup_pc+L. No redirect is raised in the setup cycle.
- R3: While a loop is active, a valid fetch of the body's last address with loop_count > 1 raises redirect_valid in that same cycle, with redirect_pc equal to the body's first address. In the next cycle, loop_count is one lower and the loop stays active.
- R4: A valid fetch of the last address with loop_count equal to 1 raises no redirect. In the next cycle, loop_count is 0 and loop_active is 0.
- R5: A fetch of any other address, or a cycle with fetch_valid low, raises no redirect and leaves loop_count and loop_active unchanged.
- R6: An accepted setup with setup_count 0 or setup_len 0 raises redirect_valid in its own cycle, with redirect_pc = setup_pc+1+setup_len. The loop never becomes active.
- R7: A setup while a loop is active does not change the count or the body range. With the default ERR_STICKY=0, setup_err is 1 for exactly the next cycle.
- R8: abort suppresses any redirect in its cycle and clears loop_active and loop_count in the next cycle. A setup in the same cycle as abort is dropped, with no load, no redirect and no error.
- R9: A loop of N passes over an L-instruction body takes exactly N*L consecutive fetch cycles, with N-1 redirects, before fetch reaches the instruction after the body. This holds when the body wraps across address zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| setup_valid | input | 1 | Decoder presents a loop-setup instruction |
| setup_pc | input | PC_W | Address of the setup instruction |
| setup_count | input | CNT_W | Number of passes through the body |
| setup_len | input | LEN_W | Body length in instructions |
| fetch_valid | input | 1 | fetch_pc holds an address being fetched |
| fetch_pc | input | PC_W | Current fetch address |
| abort | input | 1 | Flush: kill the running loop |
| redirect_valid | output | 1 | Fetch must continue at redirect_pc next |
| redirect_pc | output | PC_W | Redirect target address |
| loop_active | output | 1 | A loop is running |
| loop_count | output | CNT_W | Passes still to run, including the current one |
| setup_err | output | 1 | A setup arrived while a loop was running |

## Verification
The assertions check every cycle that a load, a decrement, the last pass and an abort each leave the count and the active flag in the state they require. They also check that an active loop never holds a zero count, that abort never coexists with a redirect, that an empty setup redirects past the body and stays inactive, and that a setup during a loop leaves the body range alone and raises the error. Only the bench scenarios can show the property that covers whole loops: N passes cost exactly N*L fetch cycles and N-1 rewinds, a body that wraps across address zero behaves the same, and a loop still rewinds to its original start after a rejected setup.

// File: rtl/hwloop_pkg.sv
package hwloop_pkg;

   // Decision taken by the controller for the current cycle
   typedef enum logic [1:0] {
      EVT_NONE   = 2'd0,
      EVT_REWIND = 2'd1,
      EVT_EXIT   = 2'd2,
      EVT_SKIP   = 2'd3
   } loop_evt_e;

   function automatic logic evt_redirects(loop_evt_e e);
      return (e == EVT_REWIND) || (e == EVT_SKIP);
   endfunction

endpackage

// File: rtl/hwloop_region.sv
module hwloop_region #(
   parameter int PC_W  = 16,
   parameter int LEN_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [PC_W-1:0]  setup_pc,
   input  logic [LEN_W-1:0] setup_len,
   output logic [PC_W-1:0]  start_pc,
   output logic [PC_W-1:0]  end_pc,
   output logic [PC_W-1:0]  skip_pc
);

   localparam int PAD_W = PC_W - LEN_W;

   generate
      if (PAD_W < 1) begin : g_bad_width
         $error("hwloop_region: PC_W must exceed LEN_W");
      end
   endgenerate

   logic [PC_W-1:0] len_ext;
   logic [PC_W-1:0] first_pc;

   assign len_ext  = {{PAD_W{1'b0}}, setup_len};
   assign first_pc = setup_pc + PC_W'(1);
   // Fall-through target for an empty setup: first address after the body
   assign skip_pc  = first_pc + len_ext;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_pc <= '0;
         end_pc   <= '0;
      end else if (load) begin
         start_pc <= first_pc;
         end_pc   <= setup_pc + len_ext;
      end
   end

   p_region_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> ($stable(start_pc) && $stable(end_pc)));

   p_region_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (end_pc - start_pc == $past(len_ext) - PC_W'(1)));

endmodule

// File: rtl/hwloop_counter.sv
module hwloop_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             dec,
   input  logic             clr,
   output logic [CNT_W-1:0] count,
   output logic             active
);

   generate
      if (CNT_W < 1) begin : g_bad_width
         $error("hwloop_counter: CNT_W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count  <= '0;
         active <= 1'b0;
      end else if (clr) begin
         count  <= '0;
         active <= 1'b0;
      end else if (load) begin
         count  <= load_val;
         active <= 1'b1;
      end else if (dec) begin
         count  <= count - CNT_W'(1);
         active <= (count != CNT_W'(1));
      end
   end

   p_active_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (count != '0));

   p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !clr) |=> (active && count == $past(load_val)));

   p_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !clr && !load && count > CNT_W'(1)) |=> (active && count == $past(count) - CNT_W'(1)));

   p_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !clr && !load && count == CNT_W'(1)) |=> (!active && count == '0));

   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!dec && !clr && !load) |=> ($stable(count) && $stable(active)));

   p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!active && count == '0));

endmodule

// File: rtl/hwloop_err.sv
module hwloop_err #(
   parameter bit ERR_STICKY = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic err
);

   generate
      if (ERR_STICKY) begin : g_sticky
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   err <= 1'b0;
            else if (clr) err <= 1'b0;
            else if (set) err <= 1'b1;
         end
      end else begin : g_pulse
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) err <= 1'b0;
            else        err <= set;
         end
         p_err_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !set |=> !err);
      end
   endgenerate

   p_err_raise_r7: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> err);

endmodule

// File: rtl/hwloop_ctrl.sv
module hwloop_ctrl
   import hwloop_pkg::*;
#(
   parameter int PC_W       = 16,
   parameter int CNT_W      = 8,
   parameter int LEN_W      = 6,
   parameter bit ERR_STICKY = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             setup_valid,
   input  logic [PC_W-1:0]  setup_pc,
   input  logic [CNT_W-1:0] setup_count,
   input  logic [LEN_W-1:0] setup_len,
   input  logic             fetch_valid,
   input  logic [PC_W-1:0]  fetch_pc,
   input  logic             abort,
   output logic             redirect_valid,
   output logic [PC_W-1:0]  redirect_pc,
   output logic             loop_active,
   output logic [CNT_W-1:0] loop_count,
   output logic             setup_err
);

   localparam logic [CNT_W-1:0] LAST_PASS = CNT_W'(1);

   generate
      if (PC_W < 2) begin : g_bad_pc
         $error("hwloop_ctrl: PC_W must be at least 2");
      end
      if (LEN_W < 1) begin : g_bad_len
         $error("hwloop_ctrl: LEN_W must be at least 1");
      end
   endgenerate

   logic            setup_take;
   logic            setup_busy;
   logic            setup_empty;
   logic            setup_load;
   logic            at_end;
   logic            final_pass;
   logic [PC_W-1:0] start_pc;
   logic [PC_W-1:0] end_pc;
   logic [PC_W-1:0] skip_pc;
   loop_evt_e       evt;

   // Setup classification: abort always wins, one loop level only
   assign setup_take  = setup_valid && !abort && !loop_active;
   assign setup_busy  = setup_valid && !abort &&  loop_active;
   assign setup_empty = setup_take && ((setup_count == '0) || (setup_len == '0));
   assign setup_load  = setup_take && !setup_empty;

   // End-of-body detection on the live fetch address
   assign at_end     = loop_active && fetch_valid && !abort && (fetch_pc == end_pc);
   assign final_pass = at_end && (loop_count == LAST_PASS);

   always_comb begin
      evt = EVT_NONE;
      if (setup_empty)     evt = EVT_SKIP;
      else if (final_pass) evt = EVT_EXIT;
      else if (at_end)     evt = EVT_REWIND;
   end

   assign redirect_valid = evt_redirects(evt);
   assign redirect_pc    = (evt == EVT_SKIP) ? skip_pc : start_pc;

   hwloop_region #(
      .PC_W  (PC_W),
      .LEN_W (LEN_W)
   ) region_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (setup_load),
      .setup_pc  (setup_pc),
      .setup_len (setup_len),
      .start_pc  (start_pc),
      .end_pc    (end_pc),
      .skip_pc   (skip_pc)
   );

   hwloop_counter #(
      .CNT_W (CNT_W)
   ) counter_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (setup_load),
      .load_val (setup_count),
      .dec      (at_end),
      .clr      (abort),
      .count    (loop_count),
      .active   (loop_active)
   );

   hwloop_err #(
      .ERR_STICKY (ERR_STICKY)
   ) err_i (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (setup_busy),
      .clr   (abort || setup_load),
      .err   (setup_err)
   );

   p_rewind_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (loop_active && fetch_valid && !abort && fetch_pc == end_pc && loop_count > LAST_PASS)
      |-> (redirect_valid && redirect_pc == start_pc));

   p_exit_no_redirect_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (loop_active && fetch_valid && !abort && fetch_pc == end_pc && loop_count == LAST_PASS)
      |-> !redirect_valid);

   p_skip_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (setup_valid && !abort && !loop_active && (setup_count == '0 || setup_len == '0))
      |-> (redirect_valid && redirect_pc == setup_pc + PC_W'(1) + PC_W'(setup_len)));

   p_skip_inactive_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (setup_valid && !abort && !loop_active && (setup_count == '0 || setup_len == '0))
      |=> !loop_active);

   p_busy_setup_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (setup_valid && !abort && loop_active) |=> (setup_err && $stable(start_pc)));

   p_abort_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      abort |-> !redirect_valid);

   p_abort_kills_r8: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> (!loop_active && loop_count == '0));

endmodule

// File: tb/hwloop_ctrl_tb.sv
`timescale 1ns/1ps
module hwloop_ctrl_tb_top;

   localparam int PC_W  = 16;
   localparam int CNT_W = 8;
   localparam int LEN_W = 6;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             setup_valid = 1'b0;
   logic [PC_W-1:0]  setup_pc = '0;
   logic [CNT_W-1:0] setup_count = '0;
   logic [LEN_W-1:0] setup_len = '0;
   logic             fetch_valid = 1'b0;
   logic [PC_W-1:0]  fetch_pc = '0;
   logic             abort = 1'b0;
   logic             redirect_valid;
   logic [PC_W-1:0]  redirect_pc;
   logic             loop_active;
   logic [CNT_W-1:0] loop_count;
   logic             setup_err;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   hwloop_ctrl #(
      .PC_W (PC_W), .CNT_W (CNT_W), .LEN_W (LEN_W), .ERR_STICKY (1'b0)
   ) dut_i (
      .clk (clk), .rst_n (rst_n),
      .setup_valid (setup_valid), .setup_pc (setup_pc),
      .setup_count (setup_count), .setup_len (setup_len),
      .fetch_valid (fetch_valid), .fetch_pc (fetch_pc), .abort (abort),
      .redirect_valid (redirect_valid), .redirect_pc (redirect_pc),
      .loop_active (loop_active), .loop_count (loop_count),
      .setup_err (setup_err)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic idle_inputs();
      setup_valid = 1'b0;
      fetch_valid = 1'b0;
      abort       = 1'b0;
   endtask

   // Drive a setup in one cycle (no fetch), leave inputs idle afterwards
   task automatic do_setup(input logic [PC_W-1:0] pc, input int n, input int l);
      setup_valid = 1'b1;
      setup_pc    = pc;
      setup_count = CNT_W'(n);
      setup_len   = LEN_W'(l);
      fetch_valid = 1'b0;
   endtask

   task automatic t_reset();
      check(loop_active == 1'b0, "R1 active", int'(loop_active), 0);
      check(loop_count == '0, "R1 count", int'(loop_count), 0);
      check(redirect_valid == 1'b0, "R1 redirect", int'(redirect_valid), 0);
      check(setup_err == 1'b0, "R1 err", int'(setup_err), 0);
   endtask

   // Full loop run with a model of the fetch stage following redirects
   task automatic t_loop(input logic [PC_W-1:0] spc, input int n, input int l);
      logic [PC_W-1:0] pc;
      logic [PC_W-1:0] endpc;
      logic [PC_W-1:0] nxt;
      int rem;
      int cycles;
      int redirs;
      bit exp_r;
      bit was_end;
      @(negedge clk);
      do_setup(spc, n, l);
      #1;
      check(redirect_valid == 1'b0, "R2 no redirect at setup", int'(redirect_valid), 0);
      @(negedge clk);
      idle_inputs();
      check(loop_active == 1'b1, "R2 active after setup", int'(loop_active), 1);
      check(int'(loop_count) == n, "R2 count loaded", int'(loop_count), n);
      pc     = spc + PC_W'(1);
      endpc  = spc + PC_W'(l);
      rem    = n;
      cycles = 0;
      redirs = 0;
      while (cycles < 5000) begin
         fetch_valid = 1'b1;
         fetch_pc    = pc;
         #1;
         was_end = (pc == endpc);
         exp_r   = was_end && (rem > 1);
         if (was_end) begin
            if (rem > 1)
               check(redirect_valid == 1'b1 && redirect_pc == spc + PC_W'(1),
                     "R3 rewind", int'(redirect_pc), int'(spc + PC_W'(1)));
            else
               check(redirect_valid == 1'b0, "R4 final pass falls through", int'(redirect_valid), 0);
         end else if (redirect_valid != exp_r) begin
            check(1'b0, "R5 redirect off end", int'(redirect_valid), 0);
         end
         if (redirect_valid) redirs++;
         nxt = redirect_valid ? redirect_pc : pc + PC_W'(1);
         cycles++;
         if (was_end) rem--;
         @(negedge clk);
         if (was_end) begin
            if (rem > 0)
               check(int'(loop_count) == rem && loop_active, "R3 count decremented", int'(loop_count), rem);
            else
               check(loop_count == '0 && !loop_active, "R4 loop ended", int'(loop_count), 0);
         end
         if (was_end && rem == 0) break;
         pc = nxt;
      end
      fetch_valid = 1'b0;
      check(cycles == n * l, "R9 fetch cycles", cycles, n * l);
      check(redirs == n - 1, "R9 redirect count", redirs, n - 1);
   endtask

   task automatic t_non_end();
      @(negedge clk);
      do_setup(16'h0200, 4, 3);
      @(negedge clk);
      idle_inputs();
      // fetch_valid low on the end address
      fetch_pc = 16'h0203;
      #1;
      check(redirect_valid == 1'b0, "R5 invalid fetch of end", int'(redirect_valid), 0);
      @(negedge clk);
      check(int'(loop_count) == 4 && loop_active, "R5 count held (invalid)", int'(loop_count), 4);
      // valid fetch of a middle address
      fetch_valid = 1'b1;
      fetch_pc    = 16'h0202;
      #1;
      check(redirect_valid == 1'b0, "R5 middle fetch", int'(redirect_valid), 0);
      @(negedge clk);
      check(int'(loop_count) == 4, "R5 count held (middle)", int'(loop_count), 4);
      // valid fetch of an address outside the body
      fetch_pc = 16'h0300;
      #1;
      check(redirect_valid == 1'b0, "R5 outside fetch", int'(redirect_valid), 0);
      @(negedge clk);
      check(int'(loop_count) == 4 && loop_active, "R5 count held (outside)", int'(loop_count), 4);
      fetch_valid = 1'b0;
      abort = 1'b1;
      @(negedge clk);
      abort = 1'b0;
   endtask

   task automatic t_skip();
      @(negedge clk);
      do_setup(16'h0400, 0, 5);
      #1;
      check(redirect_valid && redirect_pc == 16'h0406, "R6 zero count skip", int'(redirect_pc), 16'h0406);
      @(negedge clk);
      idle_inputs();
      check(loop_active == 1'b0, "R6 zero count inactive", int'(loop_active), 0);
      do_setup(16'h0500, 3, 0);
      #1;
      check(redirect_valid && redirect_pc == 16'h0501, "R6 zero length skip", int'(redirect_pc), 16'h0501);
      @(negedge clk);
      idle_inputs();
      check(loop_active == 1'b0 && loop_count == '0, "R6 zero length inactive", int'(loop_active), 0);
   endtask

   task automatic t_busy_setup();
      @(negedge clk);
      do_setup(16'h0100, 3, 2);        // body 0x101..0x102
      @(negedge clk);
      idle_inputs();
      do_setup(16'h0800, 9, 4);        // rejected
      #1;
      check(redirect_valid == 1'b0, "R7 no redirect on rejected setup", int'(redirect_valid), 0);
      @(negedge clk);
      idle_inputs();
      check(setup_err == 1'b1, "R7 error raised", int'(setup_err), 1);
      check(int'(loop_count) == 3, "R7 count unchanged", int'(loop_count), 3);
      fetch_valid = 1'b1;
      fetch_pc    = 16'h0102;
      #1;
      check(redirect_valid && redirect_pc == 16'h0101, "R7 body range unchanged", int'(redirect_pc), 16'h0101);
      @(negedge clk);
      fetch_valid = 1'b0;
      check(setup_err == 1'b0, "R7 error is one cycle", int'(setup_err), 0);
      check(int'(loop_count) == 2, "R7 loop continues", int'(loop_count), 2);
   endtask

   task automatic t_abort();
      // loop from t_busy_setup still active with count 2, end 0x102
      fetch_valid = 1'b1;
      fetch_pc    = 16'h0102;
      abort       = 1'b1;
      #1;
      check(redirect_valid == 1'b0, "R8 abort suppresses redirect", int'(redirect_valid), 0);
      @(negedge clk);
      idle_inputs();
      check(loop_active == 1'b0 && loop_count == '0, "R8 abort clears loop", int'(loop_count), 0);
      // abort together with setup while idle
      do_setup(16'h0600, 5, 2);
      abort = 1'b1;
      #1;
      check(redirect_valid == 1'b0, "R8 abort+setup no redirect", int'(redirect_valid), 0);
      @(negedge clk);
      idle_inputs();
      check(loop_active == 1'b0, "R8 setup dropped under abort", int'(loop_active), 0);
      check(setup_err == 1'b0, "R8 no error under abort", int'(setup_err), 0);
      // abort together with an empty setup: no skip redirect either
      do_setup(16'h0700, 0, 2);
      abort = 1'b1;
      #1;
      check(redirect_valid == 1'b0, "R8 abort blocks skip", int'(redirect_valid), 0);
      @(negedge clk);
      idle_inputs();
   endtask

   initial begin
      #(5ns * 150000);
      if (!finished) begin
         failures++;
         checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_loop(16'h0010, 4, 3);
      t_loop(16'h0040, 1, 5);
      t_loop(16'h0080, 5, 1);
      t_loop(16'hFFFE, 3, 4);          // body wraps across zero
      t_non_end();
      t_skip();
      t_busy_setup();
      t_abort();
      repeat (2) @(negedge clk);
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule